// File: doc/BRIEF.md
# DRAM Controller with Interleaved Row Refresh

This block lets a synchronous client reach a 4096 x 1 dynamic memory that has a single six-bit address pin set shared between row and column phases, plus active-low row strobe, column strobe and write-enable pins. A client request carries a 12-bit word address, a direction and one data bit. The controller splits the address, drives the row half and drops the row strobe, then drives the column half and drops the column strobe, and returns one read bit or stores one write bit.

The array loses charge, so a down-counter sized from the clock frequency, the retention period and the row count raises a refresh request at a fixed interval. The request stays latched until serviced. A refresh strobes one row on the row strobe alone, without a column phase. The row comes from an internal pointer that advances after every refresh and wraps after the last row. A pending refresh is taken before any new client request, but never cuts short an access already running.

The request port is valid/ready. A request is taken on a clock edge where both `req_valid` and `req_ready` are high. The client holds address, direction and data steady while valid is high and not yet accepted. `req_ready` drops while any cycle runs or while a refresh is waiting, which is the only back-pressure. The read response is a one-cycle `rsp_valid` pulse with no ready: the client must take it in that cycle.

Top module: `dram_refresh_ctrl`

## Requirements
- R1: Address bits [11:6] go out on the pins as the row and bits [5:0] as the column, so distinct addresses that swap the two halves hold independent values.
- R2: A read returns the bit last written to that address on `rsp_data`, marked by a single-cycle `rsp_valid` pulse.
- R3: Each write proceeds in this order: row strobe falls, write-enable goes low before the column strobe falls, the row strobe rises while the column strobe is still low, then the column strobe rises. The column strobe only falls while the row strobe is low.
- R4: A refresh pulses only the row strobe: the column strobe does not fall and write-enable stays high.
- R5: Refresh rows start at row 0 after reset, advance by one per refresh and wrap from 63 back to 0.
- R6: With no client traffic, successive refreshes begin exactly (CLK_FREQ_HZ/1000000) * RETENTION_US / 64 clock cycles apart.
- R7: A pending refresh is served ahead of a waiting client request, so refreshes keep their rate under back-to-back client traffic.
- R8: A refresh that falls due during a client access waits until that access completes, and the access data stays intact.
- R9: The row strobe stays high for at least T_PRE clock cycles before every fall.
- R10: `req_ready` is high only when no cycle runs and no refresh waits. After an accepted request `busy` is high and `req_ready` is low.
- R11: During and just after reset the row strobe, column strobe and write-enable are high, `busy` and `rsp_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Client request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Word address: row in [11:6], column in [5:0] |
| req_wdata | input | 1 | Write data bit |
| busy | output | 1 | An access or refresh cycle is running |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_data | output | 1 | Read data bit |
| dram_addr | output | 6 | Multiplexed row/column address pins |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_din | output | 1 | Data into the memory |
| dram_dout | input | 1 | Data from the memory, high impedance outside reads |

## Verification
Two functions can meet in the same cycle: the refresh timer falling due and a client request being presented. The bench provokes this by holding `req_valid` high with back-to-back writes across many refresh intervals, so every refresh becomes due either mid-access or while the next request is waiting. It then judges that the number of refreshes over that window matches the interval, that row order and strobe order stay correct, and that every written bit reads back.

// File: rtl/dram_ctrl_pkg.sv
package dram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_RAS,
    ST_COL,
    ST_CAS,
    ST_WB,
    ST_PRE
  } seq_state_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int INTERVAL = 3125
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pending
);
  localparam int CNT_W = $clog2(INTERVAL + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= RELOAD;
      pend_q <= 1'b0;
    end else begin
      if (cnt_q == '0) begin
        cnt_q  <= RELOAD;
        pend_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
        if (ack) pend_q <= 1'b0;
      end
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux #(
  parameter int ROW_W = 6,
  parameter int COL_W = 6,
  parameter int PIN_W = 6
) (
  input  logic             sel_col,
  input  logic             sel_ref,
  input  logic [ROW_W-1:0] row,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] ref_row,
  output logic [PIN_W-1:0] pin_addr
);
  logic [ROW_W-1:0] row_src;

  always_comb begin
    row_src  = sel_ref ? ref_row : row;
    pin_addr = sel_col ? PIN_W'(col) : PIN_W'(row_src);
  end
endmodule

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq
  import dram_ctrl_pkg::*;
#(
  parameter int ROW_W    = 6,
  parameter int COL_W    = 6,
  parameter int T_ADDR   = 1,
  parameter int T_HOLD   = 1,
  parameter int T_STROBE = 2,
  parameter int T_PRE    = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_wdata,
  input  logic                   ref_pending,
  input  logic                   dram_dout,
  output logic                   req_ready,
  output logic                   busy,
  output logic                   ref_ack,
  output logic                   rsp_valid,
  output logic                   rsp_data,
  output logic                   ras_n,
  output logic                   cas_n,
  output logic                   we_n,
  output logic                   din,
  output logic                   sel_col,
  output logic                   sel_ref,
  output logic [ROW_W-1:0]       row,
  output logic [COL_W-1:0]       col,
  output logic [ROW_W-1:0]       ref_row
);
  localparam int TMAX = max_of(max_of(T_ADDR, T_HOLD), max_of(T_STROBE, T_PRE));
  localparam int CW   = $clog2(TMAX + 1);
  localparam logic [CW-1:0] L_ADDR   = CW'(T_ADDR - 1);
  localparam logic [CW-1:0] L_HOLD   = CW'(T_HOLD - 1);
  localparam logic [CW-1:0] L_STROBE = CW'(T_STROBE - 1);
  localparam logic [CW-1:0] L_PRE    = CW'(T_PRE - 1);

  seq_state_t       state_q, state_d;
  logic [CW-1:0]    cnt_q, load_v;
  logic             move;
  logic             step;
  logic             take_user, take_ref;
  logic             is_ref_q, we_q, wd_q;
  logic [ROW_W-1:0] row_q, ref_row_q;
  logic [COL_W-1:0] col_q;
  logic             rsp_v_q, rsp_d_q;

  assign step      = (cnt_q == '0);
  assign take_ref  = (state_q == ST_IDLE) && ref_pending;
  assign take_user = (state_q == ST_IDLE) && !ref_pending && req_valid;

  always_comb begin
    state_d = state_q;
    load_v  = '0;
    move    = 1'b0;
    case (state_q)
      ST_IDLE: if (take_ref || take_user) begin
        state_d = ST_ROW; load_v = L_ADDR; move = 1'b1;
      end
      ST_ROW: if (step) begin
        state_d = ST_RAS; load_v = is_ref_q ? L_STROBE : L_HOLD; move = 1'b1;
      end
      ST_RAS: if (step) begin
        move = 1'b1;
        if (is_ref_q) begin state_d = ST_PRE; load_v = L_PRE; end
        else          begin state_d = ST_COL; load_v = L_ADDR; end
      end
      ST_COL: if (step) begin
        state_d = ST_CAS; load_v = L_STROBE; move = 1'b1;
      end
      ST_CAS: if (step) begin
        move = 1'b1;
        if (we_q) begin state_d = ST_WB;  load_v = L_STROBE; end
        else      begin state_d = ST_PRE; load_v = L_PRE;    end
      end
      ST_WB: if (step) begin
        state_d = ST_PRE; load_v = L_PRE; move = 1'b1;
      end
      ST_PRE: if (step) begin
        state_d = ST_IDLE; move = 1'b1;
      end
      default: begin
        state_d = ST_IDLE; move = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      if (move)            cnt_q <= load_v;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      is_ref_q <= 1'b0;
      we_q     <= 1'b0;
      wd_q     <= 1'b0;
      row_q    <= '0;
      col_q    <= '0;
    end else if (take_ref) begin
      is_ref_q <= 1'b1;
      we_q     <= 1'b0;
    end else if (take_user) begin
      is_ref_q <= 1'b0;
      we_q     <= req_we;
      wd_q     <= req_wdata;
      row_q    <= req_addr[ROW_W+COL_W-1:COL_W];
      col_q    <= req_addr[COL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_row_q <= '0;
    end else if (state_q == ST_RAS && step && is_ref_q) begin
      ref_row_q <= ref_row_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_v_q <= 1'b0;
      rsp_d_q <= 1'b0;
    end else begin
      rsp_v_q <= (state_q == ST_CAS) && step && !we_q;
      if ((state_q == ST_CAS) && step && !we_q) rsp_d_q <= dram_dout;
    end
  end

  always_comb begin
    ras_n   = !(state_q inside {ST_RAS, ST_COL, ST_CAS});
    cas_n   = !(state_q inside {ST_CAS, ST_WB});
    we_n    = !(we_q && !is_ref_q && (state_q inside {ST_COL, ST_CAS, ST_WB}));
    sel_col = state_q inside {ST_COL, ST_CAS, ST_WB, ST_PRE};
  end

  assign sel_ref   = is_ref_q;
  assign din       = wd_q;
  assign req_ready = (state_q == ST_IDLE) && !ref_pending;
  assign busy      = (state_q != ST_IDLE);
  assign ref_ack   = take_ref;
  assign rsp_valid = rsp_v_q;
  assign rsp_data  = rsp_d_q;
  assign row       = row_q;
  assign col       = col_q;
  assign ref_row   = ref_row_q;
endmodule

// File: rtl/dram_refresh_ctrl.sv
module dram_refresh_ctrl #(
  parameter int ROW_W        = 6,
  parameter int COL_W        = 6,
  parameter int CLK_FREQ_HZ  = 50_000_000,
  parameter int RETENTION_US = 4000,
  parameter int T_ADDR       = 1,
  parameter int T_HOLD       = 1,
  parameter int T_STROBE     = 2,
  parameter int T_PRE        = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic                   req_wdata,
  output logic                   busy,
  output logic                   rsp_valid,
  output logic                   rsp_data,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                   dram_ras_n,
  output logic                   dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_din,
  input  logic                   dram_dout
);
  localparam int ROWS     = 1 << ROW_W;
  localparam int PIN_W    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int INTERVAL = (CLK_FREQ_HZ / 1_000_000) * RETENTION_US / ROWS;

  logic             ref_pending, ref_ack;
  logic             sel_col, sel_ref;
  logic [ROW_W-1:0] row, ref_row;
  logic [COL_W-1:0] col;

  dram_refresh_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .ack     (ref_ack),
    .pending (ref_pending)
  );

  dram_strobe_seq #(
    .ROW_W(ROW_W), .COL_W(COL_W), .T_ADDR(T_ADDR), .T_HOLD(T_HOLD),
    .T_STROBE(T_STROBE), .T_PRE(T_PRE)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_we      (req_we),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .ref_pending (ref_pending),
    .dram_dout   (dram_dout),
    .req_ready   (req_ready),
    .busy        (busy),
    .ref_ack     (ref_ack),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .ras_n       (dram_ras_n),
    .cas_n       (dram_cas_n),
    .we_n        (dram_we_n),
    .din         (dram_din),
    .sel_col     (sel_col),
    .sel_ref     (sel_ref),
    .row         (row),
    .col         (col),
    .ref_row     (ref_row)
  );

  dram_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W), .PIN_W(PIN_W)) u_mux (
    .sel_col  (sel_col),
    .sel_ref  (sel_ref),
    .row      (row),
    .col      (col),
    .ref_row  (ref_row),
    .pin_addr (dram_addr)
  );
endmodule

// File: rtl/dram_refresh_ctrl_chk.sv
module dram_refresh_ctrl_chk #(
  parameter int T_PRE = 2
) (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic rsp_valid,
  input logic dram_ras_n,
  input logic dram_cas_n,
  input logic dram_we_n
);
  int hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_cnt <= T_PRE;
    else if (!dram_ras_n) hi_cnt <= 0;
    else if (hi_cnt < T_PRE) hi_cnt <= hi_cnt + 1;
  end

  AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> !dram_ras_n); // R3

  AST_WE_BEFORE_CAS: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> $past(!dram_we_n)); // R3

  AST_WE_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (dram_ras_n && dram_cas_n) |-> dram_we_n); // R4

  AST_RAS_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_cnt >= T_PRE)); // R9

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !busy); // R10

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy); // R10

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R2
endmodule

bind dram_refresh_ctrl dram_refresh_ctrl_chk #(.T_PRE(T_PRE)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .busy       (busy),
  .rsp_valid  (rsp_valid),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n)
);

// File: tb/dram_refresh_ctrl_test.sv
`timescale 1ns/1ps
module dram_refresh_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int BENCH_HZ   = 2_000_000;
  localparam int EXP_GAP    = (BENCH_HZ / 1_000_000) * 4000 / 64;
  localparam int TP         = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0, req_wdata = 1'b0;
  logic [11:0] req_addr = '0;
  logic        req_ready, busy, rsp_valid, rsp_data;
  logic [5:0]  dram_addr;
  logic        dram_ras_n, dram_cas_n, dram_we_n, dram_din, dram_dout;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_refresh_ctrl #(
    .CLK_FREQ_HZ(BENCH_HZ), .RETENTION_US(4000),
    .T_ADDR(1), .T_HOLD(1), .T_STROBE(2), .T_PRE(TP)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .busy(busy),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .dram_addr(dram_addr),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_din(dram_din), .dram_dout(dram_dout)
  );

  // behavioural memory array
  logic       mem [0:4095];
  logic       shadow [0:4095];
  logic       dout_drv = 1'bz;
  logic [5:0] m_row = '0, m_col = '0;
  bit         cas_seen = 1'b0, m_wrote = 1'b0;
  int         ref_count = 0, ref_row_err = 0, ref_we_err = 0, proto_err = 0;
  int         pre_err = 0, cas_falls = 0, ref_row_exp = 0;
  time        last_ref_t = 0, ras_rise_t = 0;

  assign dram_dout = dout_drv;

  initial for (int i = 0; i < 4096; i++) begin mem[i] = 1'b0; shadow[i] = 1'b0; end

  always @(negedge dram_ras_n) if (rst_n) begin
    if (($time - ras_rise_t) < TP * CLK_PERIOD) pre_err++;
    m_row    = dram_addr;
    cas_seen = 1'b0;
    m_wrote  = 1'b0;
  end

  always @(negedge dram_cas_n) if (rst_n) begin
    cas_falls++;
    if (dram_ras_n) proto_err++;
    m_col    = dram_addr;
    cas_seen = 1'b1;
    if (!dram_we_n) begin
      mem[{m_row, m_col}] = dram_din;
      m_wrote = 1'b1;
    end else begin
      dout_drv <= #1 mem[{m_row, m_col}];
    end
  end

  always @(posedge dram_cas_n) if (rst_n) dout_drv <= #1 1'bz;

  always @(posedge dram_ras_n) if (rst_n) begin
    ras_rise_t = $time;
    if (!cas_seen) begin
      if (m_row != ref_row_exp[5:0]) ref_row_err++;
      if (!dram_we_n) ref_we_err++;
      ref_row_exp = (ref_row_exp + 1) % 64;
      ref_count++;
      last_ref_t = $time;
    end else if (m_wrote && dram_cas_n) begin
      proto_err++;
    end
  end

  int checks = 0, fails = 0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic issue(input logic [11:0] a, input logic we, input logic wd);
    @(negedge clk);
    req_addr = a; req_we = we; req_wdata = wd; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_write(input logic [11:0] a, input logic wd);
    issue(a, 1'b1, wd);
    shadow[a] = wd;
    while (busy) @(negedge clk);
  endtask

  task automatic do_read(input logic [11:0] a, output logic d);
    int n = 0;
    issue(a, 1'b0, 1'b0);
    while (!rsp_valid && n < 100) begin @(negedge clk); n++; end
    d = rsp_data;
    while (busy) @(negedge clk);
  endtask

  task automatic t_reset();
    check(dram_ras_n && dram_cas_n && dram_we_n, "R11 strobes high in reset", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(dram_ras_n && dram_cas_n && dram_we_n, "R11 strobes high after reset", {dram_ras_n, dram_cas_n, dram_we_n}, 7);
    check(!busy && !rsp_valid, "R11 busy/rsp low", {busy, rsp_valid}, 0);
    check(req_ready, "R11 ready after reset", req_ready, 1);
  endtask

  task automatic t_basic();
    logic d;
    issue(12'h5A3, 1'b1, 1'b1);
    shadow[12'h5A3] = 1'b1;
    check(busy && !req_ready, "R10 busy after accept", {busy, req_ready}, 2);
    while (busy) @(negedge clk);
    do_read(12'h5A3, d);
    check(d === 1'b1, "R2 read back one", d, 1);
    do_write(12'h5A3, 1'b0);
    do_read(12'h5A3, d);
    check(d === 1'b0, "R2 read back zero", d, 0);
    check(proto_err == 0, "R3 write strobe order", proto_err, 0);
  endtask

  task automatic t_split();
    logic d;
    do_write({6'd5, 6'd9}, 1'b1);
    do_write({6'd9, 6'd5}, 1'b0);
    do_read({6'd5, 6'd9}, d);
    check(d === 1'b1, "R1 row/col halves distinct", d, 1);
    check(mem[{6'd5, 6'd9}] === 1'b1, "R1 cell at row 5 col 9", mem[{6'd5, 6'd9}], 1);
    do_write({6'd63, 6'd0}, 1'b1);
    check(mem[{6'd63, 6'd0}] === 1'b1 && mem[{6'd0, 6'd63}] === 1'b0, "R1 extreme row", mem[{6'd63, 6'd0}], 1);
  endtask

  task automatic t_interval();
    int  c0, cf0;
    time t1, t2;
    c0 = ref_count;
    while (ref_count == c0) @(negedge clk);
    t1 = last_ref_t; c0 = ref_count; cf0 = cas_falls;
    while (ref_count == c0) @(negedge clk);
    t2 = last_ref_t;
    check((t2 - t1) / CLK_PERIOD == EXP_GAP, "R6 idle refresh gap", int'((t2 - t1) / CLK_PERIOD), EXP_GAP);
    check(cas_falls == cf0, "R4 no column strobe in refresh", cas_falls - cf0, 0);
    check(ref_we_err == 0, "R4 write enable high in refresh", ref_we_err, 0);
  endtask

  task automatic t_wrap();
    while (ref_count < 70) @(negedge clk);
    check(ref_row_err == 0, "R5 refresh row sequence with wrap", ref_row_err, 0);
  endtask

  task automatic t_saturate();
    int  c0, got;
    time ts;
    logic d;
    int  bad = 0;
    c0 = ref_count; ts = $time;
    @(negedge clk);
    req_valid = 1'b1; req_we = 1'b1;
    for (int i = 0; i < 300; i++) begin
      req_addr  = 12'((i * 37) % 4096);
      req_wdata = ^(i * 5 + 3);
      shadow[(i * 37) % 4096] = ^(i * 5 + 3);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
    end
    req_valid = 1'b0;
    while (busy) @(negedge clk);
    got = ref_count - c0;
    c0  = int'(($time - ts) / CLK_PERIOD) / EXP_GAP;
    check(got >= c0 - 1 && got <= c0 + 1, "R7 refresh rate under load", got, c0);
    for (int i = 0; i < 300; i++) begin
      do_read(12'((i * 37) % 4096), d);
      if (d !== shadow[(i * 37) % 4096]) bad++;
    end
    check(bad == 0, "R8 data intact across refresh", bad, 0);
    check(proto_err == 0, "R3 strobe order under load", proto_err, 0);
    check(pre_err == 0, "R9 precharge width", pre_err, 0);
    check(ref_row_err == 0, "R5 refresh rows under load", ref_row_err, 0);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_split();
    t_interval();
    t_wrap();
    t_saturate();
    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      report();
      $finish;
    end
  end
endmodule